// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block gathers the interrupt sources of a full-speed USB device core into one 16-bit status register and drives a single interrupt line. The serial engine reports each event with a one-cycle pulse. A pulse sets a sticky flag, and the flag stays set until software clears it. Software clears a flag by writing zero to its position. Writing one leaves the flag as it was, so a driver can clear one flag without a read-modify-write race against the others.

A 16-bit control register sits beside the status register. It holds an enable mask for each event and the bus power and reset request bits. The interrupt output is high whenever a flag and its enable are both set. When a transfer completes, the block also records which endpoint it came from and in which direction. Software reads that endpoint number and direction in the low bits of the status register.

Top module: `usb_isr_ctrl`

## Requirements
- R1: After a synchronous reset the status output reads 0x0000, the control output reads 0x0003 (force-reset and power-down set, every mask clear), and the interrupt output is low.
- R2: A pulse on event input bit i sets status bit 8+i on the next clock edge. The event bits are: 7 correct transfer (status 15), 6 buffer overrun/underrun (14), 5 error (13), 4 wakeup (12), 3 suspend (11), 2 bus reset (10), 1 start of frame (9), 0 expected start of frame (8).
- R3: A status write clears each of flags 15..8 whose data bit is 0. It leaves unchanged each flag whose data bit is 1.
- R4: If an event pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: The interrupt output equals the OR over bits 15..8 of (status AND control), and it changes on the same clock edge as the registers it depends on.
- R6: A control write loads bits 15..8 (event enables, at the same positions as the flags) and bits 4..0 (4 resume request, 3 force suspend, 2 low-power mode, 1 power-down, 0 force reset). Control bits 7..5 always read 0.
- R7: A correct-transfer pulse loads status bits 3..0 with the endpoint number and status bit 4 with the direction (1 = IN) presented with the pulse. Status writes do not change bits 4..0, and bits 7..5 always read 0.
- R8: With no event and no write, every status and control bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 8 | One-cycle event pulses, bit map as in R2 |
| xfer_ep | input | 4 | Endpoint number of the completing transfer |
| xfer_in | input | 1 | Direction of the completing transfer, 1 = IN |
| wr_status | input | 1 | Write strobe for the status register |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wr_data | input | 16 | Write data shared by both registers |
| status | output | 16 | Status register |
| ctrl | output | 16 | Control register |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes ones to flags that are already set. A design that treated the register as write-one-to-clear, or as plainly writable, would lose those flags or set new ones. It fires an event in the same cycle as a clearing write to the same flag. Letting the clear win would drop that event. It changes the mask while a flag stays pending, and clears a flag while its enable stays set, so an interrupt line that lagged its inputs by a cycle would show up. It also writes the endpoint field through the status port; a design that let that write through would corrupt the recorded endpoint and direction.

// File: rtl/usb_isr_pkg.sv
package usb_isr_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_EVT = 8;
  localparam int EVT_LSB = REG_W - NUM_EVT;
  localparam int EP_W    = 4;

  typedef enum int {
    EVT_ESOF  = 0,
    EVT_SOF   = 1,
    EVT_BRST  = 2,
    EVT_SUSP  = 3,
    EVT_WAKE  = 4,
    EVT_ERR   = 5,
    EVT_OVR   = 6,
    EVT_XFER  = 7
  } evt_idx_e;

  localparam logic [REG_W-1:0] CTRL_RST_VAL = 16'h0003;
  localparam logic [REG_W-1:0] CTRL_WR_MASK = 16'hFF1F;
endpackage

// File: rtl/isr_flag_bank.sv
module isr_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_pulse,
  input  logic         wr_en,
  input  logic [N-1:0] wr_keep,
  output logic [N-1:0] flag_next,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      if (set_pulse[i])  flag_next[i] = 1'b1;
      else if (wr_en)    flag_next[i] = flag_q[i] & wr_keep[i];
      else               flag_next[i] = flag_q[i];
    end
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_next[i];
    end
  end
endmodule

// File: rtl/isr_ctrl_reg.sv
module isr_ctrl_reg #(
  parameter int              W       = 16,
  parameter logic [W-1:0]    RST_VAL = '0,
  parameter logic [W-1:0]    WR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_next,
  output logic [W-1:0] ctrl_q
);
  always_comb begin
    ctrl_next = wr_en ? (wr_data & WR_MASK) : ctrl_q;
  end
  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= RST_VAL;
    else     ctrl_q <= ctrl_next;
  end
endmodule

// File: rtl/isr_ep_track.sv
module isr_ep_track #(
  parameter int EPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           capture,
  input  logic [EPW-1:0] ep_in,
  input  logic           dir_in,
  output logic [EPW-1:0] ep_q,
  output logic           dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ep_q  <= '0;
      dir_q <= 1'b0;
    end else if (capture) begin
      ep_q  <= ep_in;
      dir_q <= dir_in;
    end
  end
endmodule

// File: rtl/usb_isr_ctrl.sv
module usb_isr_ctrl
  import usb_isr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [EP_W-1:0]    xfer_ep,
  input  logic               xfer_in,
  input  logic               wr_status,
  input  logic               wr_ctrl,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   status,
  output logic [REG_W-1:0]   ctrl,
  output logic               irq
);
  localparam int GAP_W = EVT_LSB - EP_W - 1;

  logic [NUM_EVT-1:0] flg_next, flg_q;
  logic [REG_W-1:0]   ctl_next, ctl_q;
  logic [EP_W-1:0]    ep_q;
  logic               dir_q;
  logic               irq_q;

  isr_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk(clk), .rst(rst),
    .set_pulse(evt_pulse),
    .wr_en(wr_status),
    .wr_keep(wr_data[REG_W-1:EVT_LSB]),
    .flag_next(flg_next),
    .flag_q(flg_q)
  );

  isr_ctrl_reg #(.W(REG_W), .RST_VAL(CTRL_RST_VAL), .WR_MASK(CTRL_WR_MASK)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr_en(wr_ctrl),
    .wr_data(wr_data),
    .ctrl_next(ctl_next),
    .ctrl_q(ctl_q)
  );

  isr_ep_track #(.EPW(EP_W)) u_ep (
    .clk(clk), .rst(rst),
    .capture(evt_pulse[EVT_XFER]),
    .ep_in(xfer_ep),
    .dir_in(xfer_in),
    .ep_q(ep_q),
    .dir_q(dir_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flg_next & ctl_next[REG_W-1:EVT_LSB]);
  end

  assign status = {flg_q, {GAP_W{1'b0}}, dir_q, ep_q};
  assign ctrl   = ctl_q;
  assign irq    = irq_q;
endmodule

// File: rtl/usb_isr_ctrl_chk.sv
module usb_isr_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  evt_pulse,
  input logic [3:0]  xfer_ep,
  input logic        xfer_in,
  input logic        wr_status,
  input logic        wr_ctrl,
  input logic [15:0] wr_data,
  input logic [15:0] status,
  input logic [15:0] ctrl,
  input logic        irq
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|evt_pulse) |=> ((status[15:8] & $past(evt_pulse)) == $past(evt_pulse)));

  assert_keep_on_one_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_status && evt_pulse == 8'h00) |=>
      (status[15:8] == ($past(status[15:8]) & $past(wr_data[15:8]))));

  assert_irq_match_R5: assert property (@(posedge clk) disable iff (rst)
    irq == |(status[15:8] & ctrl[15:8]));

  assert_ctrl_load_R6: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (ctrl == ($past(wr_data) & 16'hFF1F)));

  assert_ep_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !evt_pulse[7] |=> $stable(status[4:0]));

  assert_ep_capture_R7: assert property (@(posedge clk) disable iff (rst)
    evt_pulse[7] |=> (status[4:0] == {$past(xfer_in), $past(xfer_ep)}));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_status && !wr_ctrl && evt_pulse == 8'h00) |=> ($stable(status) && $stable(ctrl)));
endmodule

bind usb_isr_ctrl usb_isr_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .xfer_ep(xfer_ep),
  .xfer_in(xfer_in), .wr_status(wr_status), .wr_ctrl(wr_ctrl),
  .wr_data(wr_data), .status(status), .ctrl(ctrl), .irq(irq)
);

// File: tb/usb_isr_ctrl_tb.sv
module usb_isr_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt_pulse = '0;
  logic [3:0]  xfer_ep = '0;
  logic        xfer_in = 1'b0;
  logic        wr_status = 1'b0;
  logic        wr_ctrl = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] status, ctrl;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_isr_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .xfer_ep(xfer_ep),
    .xfer_in(xfer_in), .wr_status(wr_status), .wr_ctrl(wr_ctrl),
    .wr_data(wr_data), .status(status), .ctrl(ctrl), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [7:0] ev);
    evt_pulse = ev; step(); evt_pulse = '0;
  endtask

  task automatic wstat(logic [15:0] d);
    wr_status = 1'b1; wr_data = d; step(); wr_status = 1'b0;
  endtask

  task automatic wctrl(logic [15:0] d);
    wr_ctrl = 1'b1; wr_data = d; step(); wr_ctrl = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 16'h0000);
    chk("R1 ctrl", ctrl, 16'h0003);
    chk("R1 irq", {15'h0, irq}, 16'h0000);
  endtask

  task automatic t_set();
    pulse(8'b0000_0011);
    chk("R2 sof+esof", status, 16'h0300);
    pulse(8'b0100_0000);
    chk("R2 overrun", status, 16'h4300);
  endtask

  task automatic t_clear();
    wstat(16'hFFFF);
    chk("R3 write ones keeps", status, 16'h4300);
    wstat(16'hBFFF);
    chk("R3 clear one flag", status, 16'h0300);
    wstat(16'h0000);
    chk("R3 clear all", status, 16'h0000);
  endtask

  task automatic t_collide();
    pulse(8'b0000_0100);
    chk("R2 bus reset", status, 16'h0400);
    evt_pulse = 8'b0010_0000;
    wstat(16'h0000);
    evt_pulse = '0;
    chk("R4 set beats clear", status, 16'h2000);
  endtask

  task automatic t_ctrl_irq();
    wctrl(16'hFFFF);
    chk("R6 ctrl all", ctrl, 16'hFF1F);
    chk("R5 irq on mask", {15'h0, irq}, 16'h0001);
    wctrl(16'h0200);
    chk("R6 ctrl sof mask", ctrl, 16'h0200);
    chk("R5 irq off mask", {15'h0, irq}, 16'h0000);
    pulse(8'b0000_0010);
    chk("R5 status", status, 16'h2200);
    chk("R5 irq on event", {15'h0, irq}, 16'h0001);
    wstat(16'hFDFF);
    chk("R5 status cleared", status, 16'h2000);
    chk("R5 irq on clear", {15'h0, irq}, 16'h0000);
  endtask

  task automatic t_ep();
    xfer_ep = 4'd5; xfer_in = 1'b1;
    pulse(8'b1000_0000);
    xfer_ep = 4'd0; xfer_in = 1'b0;
    chk("R7 capture", status, 16'hA015);
    wstat(16'h7FE0);
    chk("R7 write ignored low bits", status, 16'h2015);
  endtask

  task automatic t_hold();
    repeat (3) step();
    chk("R8 status hold", status, 16'h2015);
    chk("R8 ctrl hold", ctrl, 16'h0200);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_set();
    t_clear();
    t_collide();
    t_ctrl_irq();
    t_ep();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule